// File: doc/BRIEF.md
# Four-Window 8 KiB Program Banking Override

This block is an alternative banking layer for the CPU program space at $8000-$FFFF. It divides that space into four 8 KiB windows, and each window has its own bank latch. A CPU write to one of two control addresses switches the override on or off. While it is on, the override's program and character bank numbers replace the bank numbers that the mode-based mapper offers at the `base_*` inputs.

The window latches are loaded by CPU writes into their own window, and only while program write protection is asserted. They keep loading while the override is off. The values they hold take effect at the moment the override is switched on, with no further write needed. Every write into $8000-$FFFF also loads a shared 2-bit character bank.

The character RAM write-protect decision stays with the mode register outside this block. Bank outputs are combinational from the latched state and the current CPU address.

Top module: `prg8k_override`

## Requirements
- R1: After synchronous reset, `ovr_active` is 0 and all four window latches and the character latch are 0. Enabling the override with no window write in between gives program bank 0 and character bank 0.
- R2: A write with `cpu_addr` = $43FE sets `ovr_active` to 1 on the clock edge that samples the write.
- R3: A write with `cpu_addr` = $43FF clears `ovr_active` to 0 on the clock edge that samples the write. Address bit 0 chooses the direction: 0 enables, 1 disables.
- R4: A write to $8000-$FFFF while `prg_wp` is 1 stores `cpu_data[7:2]` in the latch of the window named by `cpu_addr[14:13]`. The encodings are 00 = $8000-$9FFF, 01 = $A000-$BFFF, 10 = $C000-$DFFF and 11 = $E000-$FFFF. While the override is active, `prg_bank` for any address in that window equals the stored value.
- R5: A write to $8000-$FFFF while `prg_wp` is 1 stores `cpu_data[1:0]` as the character bank, whichever window is written. While the override is active, `chr_bank` equals it.
- R6: While `ovr_active` is 0, `prg_bank` equals `base_prg_bank` and `chr_bank` equals `base_chr_bank`.
- R7: Latch writes made while the override is off are stored without changing the outputs. They appear at `prg_bank` and `chr_bank` as soon as $43FE is written.
- R8: Writes to $8000-$FFFF while `prg_wp` is 0 leave every latch unchanged.
- R9: Writes to addresses below $8000 other than $43FE/$43FF change neither the latches nor `ovr_active`.
- R10: A write to one window leaves the other three window latches unchanged.
- R11: While the override is active, `prg_bank` for an address below $8000 equals `base_prg_bank`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address of the current access |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | Write strobe, one cycle per write |
| prg_wp | input | 1 | Program write protection active; gates latch loads |
| base_prg_bank | input | 6 | 8 KiB program bank from the mode-based mapper |
| base_chr_bank | input | 2 | Character bank from the mode-based mapper |
| prg_bank | output | 6 | 8 KiB program bank for the current `cpu_addr` |
| chr_bank | output | 2 | Selected 8 KiB character RAM bank |
| ovr_active | output | 1 | Override enabled |

## Verification
Every register in the block loads on the rising edge that samples `cpu_wr`. A write's effect on `ovr_active`, `prg_bank` and `chr_bank` is therefore due one edge after the write is presented, and nothing is due later than that. `prg_bank` also follows `cpu_addr` combinationally in the same cycle. The bench drives each write on a falling edge and removes it at the next falling edge. It then puts a probe address on the bus and compares 1 ns later, so each comparison sees the state after exactly one capturing edge. Invisible latch contents (writes while off, or while unprotected) are made observable by enabling the override afterwards and probing each window.

// File: rtl/gdr8k_pkg.sv
package gdr8k_pkg;

    localparam int ADDR_W_D     = 16;
    localparam int DATA_W_D     = 8;
    localparam int NUM_WIN_D    = 4;
    localparam int PRG_W_D      = 6;
    localparam int CHR_W_D      = 2;
    localparam logic [15:0] TOGGLE_ADDR_D = 16'h43FE;

    // Direction decoded from the low address bit of a toggle write.
    typedef enum logic {
        OVR_ON  = 1'b0,
        OVR_OFF = 1'b1
    } ovr_cmd_e;

    // Returns the enable state that a toggle command leaves behind.
    function automatic logic cmd_to_enable(input ovr_cmd_e cmd);
        return (cmd == OVR_ON);
    endfunction

endpackage

// File: rtl/ovr_toggle_ctl.sv
module ovr_toggle_ctl
    import gdr8k_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_D,
    parameter logic [ADDR_W-1:0] TOGGLE_ADDR = ADDR_W'(TOGGLE_ADDR_D)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output logic              enabled
);
    logic     hit;
    ovr_cmd_e cmd;

    assign hit = wr && (addr[ADDR_W-1:1] == TOGGLE_ADDR[ADDR_W-1:1]);
    assign cmd = ovr_cmd_e'(addr[0]);

    always_ff @(posedge clk) begin
        if (rst)
            enabled <= 1'b0;
        else if (hit)
            enabled <= cmd_to_enable(cmd);
    end
endmodule

// File: rtl/win_latch_file.sv
module win_latch_file
    import gdr8k_pkg::*;
#(
    parameter int DATA_W  = DATA_W_D,
    parameter int NUM_WIN = NUM_WIN_D,
    parameter int PRG_W   = PRG_W_D,
    parameter int CHR_W   = CHR_W_D,
    localparam int IDX_W  = $clog2(NUM_WIN)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr,
    input  logic                          wp,
    input  logic                          in_rom,
    input  logic [IDX_W-1:0]              win_idx,
    input  logic [DATA_W-1:0]             data,
    output logic [NUM_WIN-1:0][PRG_W-1:0] win_bank,
    output logic [CHR_W-1:0]              chr_q
);
    logic load;

    // Latches follow the mode latch: loaded only under write protection.
    assign load = wr && wp && in_rom;

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        always_ff @(posedge clk) begin
            if (rst)
                win_bank[w] <= '0;
            else if (load && (win_idx == IDX_W'(w)))
                win_bank[w] <= data[DATA_W-1 -: PRG_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            chr_q <= '0;
        else if (load)
            chr_q <= data[CHR_W-1:0];
    end
endmodule

// File: rtl/bank_out_mux.sv
module bank_out_mux
    import gdr8k_pkg::*;
#(
    parameter int NUM_WIN = NUM_WIN_D,
    parameter int PRG_W   = PRG_W_D,
    parameter int CHR_W   = CHR_W_D,
    localparam int IDX_W  = $clog2(NUM_WIN)
) (
    input  logic                          active,
    input  logic                          in_rom,
    input  logic [IDX_W-1:0]              win_idx,
    input  logic [NUM_WIN-1:0][PRG_W-1:0] win_bank,
    input  logic [CHR_W-1:0]              chr_q,
    input  logic [PRG_W-1:0]              base_prg,
    input  logic [CHR_W-1:0]              base_chr,
    output logic [PRG_W-1:0]              prg_out,
    output logic [CHR_W-1:0]              chr_out
);
    always_comb begin
        prg_out = base_prg;
        chr_out = base_chr;
        if (active) begin
            chr_out = chr_q;
            if (in_rom)
                prg_out = win_bank[win_idx];
        end
    end
endmodule

// File: rtl/prg8k_override.sv
module prg8k_override
    import gdr8k_pkg::*;
#(
    parameter int ADDR_W  = ADDR_W_D,
    parameter int DATA_W  = DATA_W_D,
    parameter int NUM_WIN = NUM_WIN_D,
    parameter int PRG_W   = PRG_W_D,
    parameter int CHR_W   = CHR_W_D,
    parameter logic [ADDR_W-1:0] TOGGLE_ADDR = ADDR_W'(TOGGLE_ADDR_D)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_data,
    input  logic              cpu_wr,
    input  logic              prg_wp,
    input  logic [PRG_W-1:0]  base_prg_bank,
    input  logic [CHR_W-1:0]  base_chr_bank,
    output logic [PRG_W-1:0]  prg_bank,
    output logic [CHR_W-1:0]  chr_bank,
    output logic              ovr_active
);
    localparam int IDX_W = $clog2(NUM_WIN);

    logic                          in_rom;
    logic [IDX_W-1:0]              win_idx;
    logic [NUM_WIN-1:0][PRG_W-1:0] win_bank;
    logic [CHR_W-1:0]              chr_q;

    // Upper half of the address space, split by the bits just below the top.
    assign in_rom  = cpu_addr[ADDR_W-1];
    assign win_idx = cpu_addr[ADDR_W-2 -: IDX_W];

    ovr_toggle_ctl #(
        .ADDR_W      (ADDR_W),
        .TOGGLE_ADDR (TOGGLE_ADDR)
    ) u_toggle (
        .clk     (clk),
        .rst     (rst),
        .wr      (cpu_wr),
        .addr    (cpu_addr),
        .enabled (ovr_active)
    );

    win_latch_file #(
        .DATA_W  (DATA_W),
        .NUM_WIN (NUM_WIN),
        .PRG_W   (PRG_W),
        .CHR_W   (CHR_W)
    ) u_latches (
        .clk      (clk),
        .rst      (rst),
        .wr       (cpu_wr),
        .wp       (prg_wp),
        .in_rom   (in_rom),
        .win_idx  (win_idx),
        .data     (cpu_data),
        .win_bank (win_bank),
        .chr_q    (chr_q)
    );

    bank_out_mux #(
        .NUM_WIN (NUM_WIN),
        .PRG_W   (PRG_W),
        .CHR_W   (CHR_W)
    ) u_mux (
        .active   (ovr_active),
        .in_rom   (in_rom),
        .win_idx  (win_idx),
        .win_bank (win_bank),
        .chr_q    (chr_q),
        .base_prg (base_prg_bank),
        .base_chr (base_chr_bank),
        .prg_out  (prg_bank),
        .chr_out  (chr_bank)
    );
endmodule

// File: rtl/prg8k_override_chk.sv
module prg8k_override_chk
    import gdr8k_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_D,
    parameter int DATA_W = DATA_W_D,
    parameter int PRG_W  = PRG_W_D,
    parameter int CHR_W  = CHR_W_D,
    parameter logic [ADDR_W-1:0] TOGGLE_ADDR = ADDR_W'(TOGGLE_ADDR_D)
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic [DATA_W-1:0] cpu_data,
    input logic              cpu_wr,
    input logic              prg_wp,
    input logic [PRG_W-1:0]  base_prg_bank,
    input logic [CHR_W-1:0]  base_chr_bank,
    input logic [PRG_W-1:0]  prg_bank,
    input logic [CHR_W-1:0]  chr_bank,
    input logic              ovr_active
);
    logic on_wr, off_wr, rom_ld;
    assign on_wr  = cpu_wr && (cpu_addr == TOGGLE_ADDR);
    assign off_wr = cpu_wr && (cpu_addr == (TOGGLE_ADDR | ADDR_W'(1)));
    assign rom_ld = cpu_wr && prg_wp && cpu_addr[ADDR_W-1];

    AST_ENABLE_ON: assert property (@(posedge clk) disable iff (rst)
        on_wr |=> ovr_active);  // R2

    AST_DISABLE_OFF: assert property (@(posedge clk) disable iff (rst)
        off_wr |=> !ovr_active);  // R3

    AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(on_wr || off_wr) |=> $stable(ovr_active));  // R9

    AST_PASS_THRU: assert property (@(posedge clk) disable iff (rst)
        !ovr_active |-> (prg_bank == base_prg_bank && chr_bank == base_chr_bank));  // R6

    AST_CHR_LOAD: assert property (@(posedge clk) disable iff (rst)
        (ovr_active && rom_ld) |=> (chr_bank == $past(cpu_data[CHR_W-1:0])));  // R5

    AST_CHR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ovr_active && !cpu_wr && $stable(base_chr_bank)) |=> $stable(chr_bank));  // R8

    AST_LOW_BASE: assert property (@(posedge clk) disable iff (rst)
        !cpu_addr[ADDR_W-1] |-> (prg_bank == base_prg_bank));  // R11
endmodule

bind prg8k_override prg8k_override_chk #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .PRG_W       (PRG_W),
    .CHR_W       (CHR_W),
    .TOGGLE_ADDR (TOGGLE_ADDR)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .cpu_addr      (cpu_addr),
    .cpu_data      (cpu_data),
    .cpu_wr        (cpu_wr),
    .prg_wp        (prg_wp),
    .base_prg_bank (base_prg_bank),
    .base_chr_bank (base_chr_bank),
    .prg_bank      (prg_bank),
    .chr_bank      (chr_bank),
    .ovr_active    (ovr_active)
);

// File: tb/sim_prg8k_override.sv
`timescale 1ns/1ps
module sim_prg8k_override;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] cpu_addr;
    logic [7:0]  cpu_data;
    logic        cpu_wr;
    logic        prg_wp;
    logic [5:0]  base_prg_bank;
    logic [1:0]  base_chr_bank;
    logic [5:0]  prg_bank;
    logic [1:0]  chr_bank;
    logic        ovr_active;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    prg8k_override u0 (
        .clk           (clk),
        .rst           (rst),
        .cpu_addr      (cpu_addr),
        .cpu_data      (cpu_data),
        .cpu_wr        (cpu_wr),
        .prg_wp        (prg_wp),
        .base_prg_bank (base_prg_bank),
        .base_chr_bank (base_chr_bank),
        .prg_bank      (prg_bank),
        .chr_bank      (chr_bank),
        .ovr_active    (ovr_active)
    );

    typedef struct packed {
        logic        wr;
        logic        wp;
        logic [15:0] addr;
        logic [7:0]  data;
        logic [15:0] probe;
        logic        act;
        logic [5:0]  prg;
        logic [1:0]  chr;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 16;
    // Base inputs held at prg 6'h2A, chr 2'd3 for the whole table.
    localparam vec_t VT [NV] = '{
        '{1'b0, 1'b1, 16'h0000, 8'h00, 16'h8000, 1'b0, 6'h2A, 2'd3, 4'd1},  // R1 idle after reset
        '{1'b1, 1'b1, 16'h43FE, 8'h00, 16'h8000, 1'b1, 6'h00, 2'd0, 4'd2},  // R2, cleared latches
        '{1'b1, 1'b1, 16'h8000, 8'h55, 16'h8000, 1'b1, 6'h15, 2'd1, 4'd4},  // R4 window 0
        '{1'b1, 1'b1, 16'hA000, 8'hFE, 16'hA123, 1'b1, 6'h3F, 2'd2, 4'd5},  // R5 chr from any window
        '{1'b0, 1'b1, 16'h0000, 8'h00, 16'h8000, 1'b1, 6'h15, 2'd2, 4'd10}, // R10 window 0 kept
        '{1'b1, 1'b0, 16'hC000, 8'h0B, 16'hC000, 1'b1, 6'h00, 2'd2, 4'd8},  // R8 unprotected ignored
        '{1'b1, 1'b1, 16'hDFFF, 8'h0B, 16'hC000, 1'b1, 6'h02, 2'd3, 4'd4},  // R4 window 2
        '{1'b1, 1'b1, 16'hE000, 8'h80, 16'hFFFF, 1'b1, 6'h20, 2'd0, 4'd4},  // R4 window 3
        '{1'b1, 1'b1, 16'h43FF, 8'h00, 16'h8000, 1'b0, 6'h2A, 2'd3, 4'd3},  // R3 disable
        '{1'b1, 1'b1, 16'h9FFF, 8'h24, 16'h8000, 1'b0, 6'h2A, 2'd3, 4'd7},  // R7 stored, hidden
        '{1'b1, 1'b1, 16'h43FD, 8'h00, 16'h8000, 1'b0, 6'h2A, 2'd3, 4'd9},  // R9 near miss
        '{1'b1, 1'b1, 16'h43FE, 8'h00, 16'h8000, 1'b1, 6'h09, 2'd0, 4'd7},  // R7 applied at enable
        '{1'b0, 1'b1, 16'h0000, 8'h00, 16'hE5A5, 1'b1, 6'h20, 2'd0, 4'd10}, // R10 window 3 kept
        '{1'b1, 1'b1, 16'h7000, 8'hFF, 16'hA000, 1'b1, 6'h3F, 2'd0, 4'd9},  // R9 low write
        '{1'b1, 1'b1, 16'h42FE, 8'hFF, 16'h6000, 1'b1, 6'h2A, 2'd0, 4'd11}, // R11 low probe
        '{1'b0, 1'b1, 16'h0000, 8'h00, 16'hBFFF, 1'b1, 6'h3F, 2'd0, 4'd10}  // R10 window 1 kept
    };

    task automatic check(input string tag, input logic act, input logic [5:0] prg,
                         input logic [1:0] chr);
        n_chk++;
        if (ovr_active !== act || prg_bank !== prg || chr_bank !== chr) begin
            n_bad++;
            $display("FAIL %s: got act=%0b prg=%h chr=%0d, expected act=%0b prg=%h chr=%0d",
                     tag, ovr_active, prg_bank, chr_bank, act, prg, chr);
        end
    endtask

    // Present a write for one clock, then place the probe address and settle.
    task automatic bus_cycle(input logic wr, input logic wp, input logic [15:0] a,
                             input logic [7:0] d, input logic [15:0] probe);
        @(negedge clk);
        cpu_wr   = wr;
        prg_wp   = wp;
        cpu_addr = a;
        cpu_data = d;
        @(negedge clk);
        cpu_wr   = 1'b0;
        cpu_addr = probe;
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #400000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1; cpu_addr = '0; cpu_data = '0; cpu_wr = 1'b0; prg_wp = 1'b1;
        base_prg_bank = 6'h2A; base_chr_bank = 2'd3;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            bus_cycle(VT[i].wr, VT[i].wp, VT[i].addr, VT[i].data, VT[i].probe);
            check($sformatf("R%0d vec%0d", VT[i].req, i), VT[i].act, VT[i].prg, VT[i].chr);
        end

        // R6: base inputs followed while off, including new values
        bus_cycle(1'b1, 1'b1, 16'h43FF, 8'h00, 16'hC000);
        base_prg_bank = 6'h11; base_chr_bank = 2'd1;
        #1;
        check("R6 new base", 1'b0, 6'h11, 2'd1);

        // R1: reset mid-run clears state
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0; #1;
        check("R1 reset idle", 1'b0, 6'h11, 2'd1);
        bus_cycle(1'b1, 1'b1, 16'h43FE, 8'h00, 16'hE000);
        check("R1 window3 cleared", 1'b1, 6'h00, 2'd0);
        cpu_addr = 16'hA000; #1;
        check("R1 window1 cleared", 1'b1, 6'h00, 2'd0);

        // R8: unprotected write to every window leaves all latches at zero
        for (int w = 0; w < 4; w++) begin
            bus_cycle(1'b1, 1'b0, 16'h8000 + 16'(w) * 16'h2000, 8'hFF,
                      16'h8000 + 16'(w) * 16'h2000);
            check($sformatf("R8 window%0d", w), 1'b1, 6'h00, 2'd0);
        end

        // R2 + R3: a disable then re-enable keeps window contents
        bus_cycle(1'b1, 1'b1, 16'hC010, 8'hFD, 16'hC010);
        check("R4 window2 top bank", 1'b1, 6'h3F, 2'd1);
        bus_cycle(1'b1, 1'b1, 16'h43FF, 8'h00, 16'hC010);
        check("R3 off again", 1'b0, 6'h11, 2'd1);
        bus_cycle(1'b1, 1'b0, 16'h43FE, 8'h00, 16'hC010);
        check("R2 on without protection", 1'b1, 6'h3F, 2'd1);

        finish_run();
    end
endmodule